// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block owns a single active-high power-enable line that feeds an external power-management device. Software arms it by setting an ownership bit in a control register. Once armed, a match pulse from a second calendar alarm, which a separate counter produces, switches the line off. Switching power off is therefore scheduled by the clock and not by a direct command.

While power is off, up to four external wakeup pins can switch the line back on. Each pin has its own enable bit and its own polarity bit. The polarity defaults to active low. Every pin passes through a two-flop synchronizer and must then hold its active level for a number of consecutive samples, so a short glitch cannot restore power.

A small word-addressed register port gives access to three registers: control, status and interrupt enable. The status register holds the second-alarm flag and a wakeup flag, and both are cleared by writing 1. An interrupt output follows the second-alarm flag when its enable bit is set.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After synchronous reset the outputs and registers take these values: `pwr_en` is 1 and `irq` is 0. The control register reads 0x000000F0, meaning all polarities active low and nothing enabled. The status and interrupt-enable registers read 0.
- R2: The register map is word-addressed, and `reg_rdata` returns the addressed register one cycle after `reg_addr` is presented.
  - Address 0 is control. Bit 16 is ownership, bits 3..0 are the wakeup enables, and bits 7..4 are the polarities.
  - Address 1 is status. Bit 7 is the second-alarm flag and bit 0 is the wakeup flag.
  - Address 2 is interrupt enable, with bit 4 as the second-alarm enable.
  - Address 3 and all unimplemented bits read 0.
- R3: With ownership (control bit 16) set, an `alarm2_hit` sampled while power is on makes `pwr_en` read 0 right after that clock edge.
- R4: With ownership clear, `alarm2_hit` leaves `pwr_en` at 1. Clearing ownership while power is off brings `pwr_en` back to 1 one clock after the register write takes effect.
- R5: Every sampled `alarm2_hit` sets status bit 7, whatever the ownership bit holds. Writing 1 to bit 7 clears it. A new hit in the same cycle as the clearing write wins, and the flag stays set.
- R6: `irq` equals the status bit 7 flag ANDed with interrupt-enable bit 4, registered one clock later.
- R7: Control bit 4+i set to 1 makes wakeup input i active low, and 0 makes it active high. When input i is enabled and power is off, holding it at its active level makes `pwr_en` rise on the fourth rising clock edge after the level is applied.
- R8: A wakeup input must be seen active on two consecutive synchronized samples. A one-cycle pulse never restores power, while a two-cycle pulse does.
- R9: A wakeup input whose enable bit (control bit i) is 0 has no effect on `pwr_en`, at either polarity.
- R10: Status bit 0 is set exactly when a wakeup turns power back on, and writing 1 to bit 0 clears it. Wakeup activity while power is already on leaves the flag and `pwr_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm2_hit | input | 1 | One-cycle second-alarm match pulse from the calendar counter |
| wake_in | input | NUM_WAKE | Asynchronous external wakeup pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| pwr_en | output | 1 | Power-enable toward the power manager, 1 means power on |
| irq | output | 1 | Second-alarm interrupt request |

## Verification
The bench uses the defaults: four wakeup pins, two synchronizer stages and a two-sample qualifier. It then sweeps every pin against both polarities and both enable settings. Each of those sixteen cases runs a full power-off and wakeup cycle, and the bench predicts the exact edge on which power returns from the pipeline depth. With this small configuration it also tries one-cycle and two-cycle pulses on each pin, exercises the clear-versus-set collision on the alarm flag, and releases ownership while power is off.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic {
    PS_OFF = 1'b0,
    PS_ON  = 1'b1
  } pwr_state_t;

  // control register fields
  localparam int CTRL_OWN_BIT = 16;
  localparam int POL_LSB      = 4;
  // status register fields
  localparam int STAT_A2_BIT  = 7;
  localparam int STAT_WK_BIT  = 0;
  // interrupt enable field
  localparam int IE_A2_BIT    = 4;

  // word addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_IE   = 2;

endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
  parameter int NUM_WAKE     = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_WAKE-1:0] pins,
  input  logic [NUM_WAKE-1:0] pol_low,
  output logic [NUM_WAKE-1:0] qual
);

  localparam int CNT_W   = (QUAL_SAMPLES > 1) ? $clog2(QUAL_SAMPLES) : 1;
  localparam int CNT_TOP = (QUAL_SAMPLES > 1) ? QUAL_SAMPLES - 1 : 0;

  for (genvar gi = 0; gi < NUM_WAKE; gi++) begin : g_pin
    logic [SYNC_STAGES-1:0] sh;
    logic [CNT_W-1:0]       run;
    logic                   act;

    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SYNC_STAGES-2:0], pins[gi]};
    end

    // active level: high when polarity bit is 0, low when it is 1
    assign act = sh[SYNC_STAGES-1] ^ pol_low[gi];

    always_ff @(posedge clk) begin
      if (rst || !act)               run <= '0;
      else if (run != CNT_W'(CNT_TOP)) run <= run + 1'b1;
    end

    assign qual[gi] = act && (run == CNT_W'(CNT_TOP));
  end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic own_en,
  input  logic alarm2_hit,
  input  logic wake_any,
  output logic pwr_en,
  output logic wake_event
);

  pwr_state_t state_q, state_d;

  always_comb begin
    state_d    = state_q;
    wake_event = 1'b0;
    unique case (state_q)
      PS_ON: begin
        if (own_en && alarm2_hit) state_d = PS_OFF;
      end
      PS_OFF: begin
        if (!own_en) begin
          state_d = PS_ON;
        end else if (wake_any) begin
          state_d    = PS_ON;
          wake_event = 1'b1;
        end
      end
      default: state_d = PS_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PS_ON;
    else     state_q <= state_d;
  end

  assign pwr_en = (state_q == PS_ON);

endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                alarm2_hit,
  input  logic                wake_event,
  output logic                ctrl_own,
  output logic [NUM_WAKE-1:0] wake_en,
  output logic [NUM_WAKE-1:0] wake_pol,
  output logic                a2_ie,
  output logic                a2_flag,
  output logic                wk_flag,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);

  logic              sel_ctrl, sel_stat, sel_ie;
  logic              clr_a2, clr_wk;
  logic [DATA_W-1:0] rd_mux;

  assign sel_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
  assign sel_stat = (reg_addr == ADDR_W'(ADDR_STAT));
  assign sel_ie   = (reg_addr == ADDR_W'(ADDR_IE));
  assign clr_a2   = reg_we && sel_stat && reg_wdata[STAT_A2_BIT];
  assign clr_wk   = reg_we && sel_stat && reg_wdata[STAT_WK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_own <= 1'b0;
      wake_en  <= '0;
      wake_pol <= '1;
      a2_ie    <= 1'b0;
    end else if (reg_we) begin
      if (sel_ctrl) begin
        ctrl_own <= reg_wdata[CTRL_OWN_BIT];
        wake_en  <= reg_wdata[NUM_WAKE-1:0];
        wake_pol <= reg_wdata[POL_LSB +: NUM_WAKE];
      end
      if (sel_ie) a2_ie <= reg_wdata[IE_A2_BIT];
    end
  end

  // sticky flags: a new event outranks a clearing write
  always_ff @(posedge clk) begin
    if (rst) begin
      a2_flag <= 1'b0;
      wk_flag <= 1'b0;
    end else begin
      a2_flag <= alarm2_hit | (a2_flag & ~clr_a2);
      wk_flag <= wake_event | (wk_flag & ~clr_wk);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[CTRL_OWN_BIT]         = ctrl_own;
      rd_mux[NUM_WAKE-1:0]         = wake_en;
      rd_mux[POL_LSB +: NUM_WAKE]  = wake_pol;
    end else if (sel_stat) begin
      rd_mux[STAT_A2_BIT] = a2_flag;
      rd_mux[STAT_WK_BIT] = wk_flag;
    end else if (sel_ie) begin
      rd_mux[IE_A2_BIT] = a2_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= a2_flag & a2_ie;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_WAKE     = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alarm2_hit,
  input  logic [NUM_WAKE-1:0] wake_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                pwr_en,
  output logic                irq
);

  logic                ctrl_own;
  logic [NUM_WAKE-1:0] wake_en, wake_pol, wake_qual;
  logic                a2_ie, a2_flag, wk_flag;
  logic                wake_any, wake_event;

  pwr_regs #(
    .NUM_WAKE (NUM_WAKE),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) regs_i (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .alarm2_hit (alarm2_hit),
    .wake_event (wake_event),
    .ctrl_own   (ctrl_own),
    .wake_en    (wake_en),
    .wake_pol   (wake_pol),
    .a2_ie      (a2_ie),
    .a2_flag    (a2_flag),
    .wk_flag    (wk_flag),
    .reg_rdata  (reg_rdata),
    .irq        (irq)
  );

  pwr_wake_filter #(
    .NUM_WAKE     (NUM_WAKE),
    .SYNC_STAGES  (SYNC_STAGES),
    .QUAL_SAMPLES (QUAL_SAMPLES)
  ) filt_i (
    .clk     (clk),
    .rst     (rst),
    .pins    (wake_in),
    .pol_low (wake_pol),
    .qual    (wake_qual)
  );

  assign wake_any = |(wake_qual & wake_en);

  pwr_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .own_en     (ctrl_own),
    .alarm2_hit (alarm2_hit),
    .wake_any   (wake_any),
    .pwr_en     (pwr_en),
    .wake_event (wake_event)
  );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic alarm2_hit,
  input logic pwr_en,
  input logic ctrl_own,
  input logic a2_flag,
  input logic wk_flag
);

  assert_reset_on_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pwr_en);

  assert_alarm_cuts_R3: assert property (@(posedge clk) disable iff (rst)
    (alarm2_hit && ctrl_own && pwr_en) |=> !pwr_en);

  assert_fall_needs_alarm_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> $past(alarm2_hit));

  assert_release_on_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_own |=> pwr_en);

  assert_flag_sets_R5: assert property (@(posedge clk) disable iff (rst)
    alarm2_hit |=> a2_flag);

  assert_wake_flag_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(wk_flag) |-> $rose(pwr_en));

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .alarm2_hit (alarm2_hit),
  .pwr_en     (pwr_en),
  .ctrl_own   (ctrl_own),
  .a2_flag    (a2_flag),
  .wk_flag    (wk_flag)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;

  localparam int NW = 4;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alarm2_hit = 1'b0;
  logic [NW-1:0] wake_in = '1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          pwr_en, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .alarm2_hit (alarm2_hit),
    .wake_in    (wake_in),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pwr_en     (pwr_en),
    .irq        (irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_addr  = AW'(a);
    reg_wdata = d;
    reg_we    = 1'b1;
    tick();
    reg_we    = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a);
    tick();
    d = reg_rdata;
  endtask

  task automatic fire_alarm();
    alarm2_hit = 1'b1;
    tick();
    alarm2_hit = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst = 1'b0;

    // R1 reset state
    chk("R1 pwr_en", 32'(pwr_en), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(0, v); chk("R1 ctrl", v, 32'h0000_00F0);
    rd(1, v); chk("R1 status", v, 32'h0);
    rd(2, v); chk("R1 ie", v, 32'h0);

    // R2 register map and unimplemented bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 ctrl mask", v, 32'h0001_00FF);
    wr(0, 32'h0000_00F0);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R2 ie mask", v, 32'h0000_0010);
    rd(3, v); chk("R2 addr3", v, 32'h0);

    // R4 alarm without ownership, R5 flag, R6 irq
    fire_alarm();
    chk("R4 no cut", 32'(pwr_en), 32'd1);
    chk("R6 irq lag", 32'(irq), 32'd0);
    tick();
    chk("R6 irq set", 32'(irq), 32'd1);
    chk("R4 still on", 32'(pwr_en), 32'd1);
    rd(1, v); chk("R5 flag set", v, 32'h80);
    wr(1, 32'h80);
    tick();
    chk("R6 irq clear", 32'(irq), 32'd0);
    rd(1, v); chk("R5 w1c", v, 32'h0);

    // R5 set wins over clear in the same cycle
    alarm2_hit = 1'b1;
    wr(1, 32'h80);
    alarm2_hit = 1'b0;
    rd(1, v); chk("R5 set wins", v, 32'h80);
    wr(1, 32'h80);
    wr(2, 32'h0);
    fire_alarm();
    tick(); tick();
    chk("R6 irq masked", 32'(irq), 32'd0);
    wr(1, 32'h80);

    // R3 cut with ownership, R4 release by clearing ownership
    wr(0, 32'h0001_00F0);
    fire_alarm();
    chk("R3 cut", 32'(pwr_en), 32'd0);
    wr(0, 32'h0000_00F0);
    chk("R4 release lag", 32'(pwr_en), 32'd0);
    tick();
    chk("R4 release", 32'(pwr_en), 32'd1);
    wr(1, 32'h81);

    // R7 / R9 / R10 sweep: pin x polarity x enable
    for (int i = 0; i < NW; i++) begin
      for (int p = 0; p < 2; p++) begin
        for (int e = 0; e < 2; e++) begin
          logic [NW-1:0] pol;
          logic [NW-1:0] en;
          pol = (p != 0) ? '1 : '0;
          en  = (e != 0) ? NW'(1 << i) : '0;
          wake_in = pol;
          wr(0, 32'h0001_0000 | (32'(pol) << 4) | 32'(en));
          repeat (4) tick();
          fire_alarm();
          chk($sformatf("R3 off pin%0d p%0d e%0d", i, p, e), 32'(pwr_en), 32'd0);
          wake_in[i] = ~pol[i];
          repeat (3) tick();
          chk($sformatf("R7 latency pin%0d p%0d", i, p), 32'(pwr_en), 32'd0);
          tick();
          if (e != 0) chk($sformatf("R7 wake pin%0d p%0d", i, p), 32'(pwr_en), 32'd1);
          else        chk($sformatf("R9 ignored pin%0d p%0d", i, p), 32'(pwr_en), 32'd0);
          repeat (3) tick();
          chk($sformatf("R9 hold pin%0d p%0d e%0d", i, p, e), 32'(pwr_en), 32'(e));
          wake_in = pol;
          rd(1, v);
          chk($sformatf("R10 flag pin%0d p%0d e%0d", i, p, e), v, 32'h80 | 32'(e));
          wr(1, 32'h81);
          wr(0, 32'(pol) << 4);
          tick();
        end
      end
    end

    // R8 glitch filter: one-cycle pulse rejected, two-cycle pulse accepted
    for (int i = 0; i < NW; i++) begin
      wake_in = '1;
      wr(0, 32'h0001_00FF);
      repeat (4) tick();
      fire_alarm();
      wake_in[i] = 1'b0;
      tick();
      wake_in[i] = 1'b1;
      repeat (6) tick();
      chk($sformatf("R8 short pulse pin%0d", i), 32'(pwr_en), 32'd0);
      wake_in[i] = 1'b0;
      tick(); tick();
      wake_in[i] = 1'b1;
      repeat (3) tick();
      chk($sformatf("R8 long pulse pin%0d", i), 32'(pwr_en), 32'd1);
      wr(1, 32'h81);
    end

    // R10 wake activity while power is on changes nothing
    wake_in = '1;
    wr(0, 32'h0001_00FF);
    repeat (4) tick();
    wake_in = '0;
    repeat (6) tick();
    chk("R10 on ignored pwr", 32'(pwr_en), 32'd1);
    rd(1, v); chk("R10 on ignored flag", v, 32'h0);
    wake_in = '1;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule